// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Controller

This block keeps the exception state of a floating-point unit. After each finished operation the arithmetic side gives it a raw status: whether the unrounded result was tiny, whether it was exactly zero, and whether it was inexact. It also reports overflow, invalid and the zero class of the divide operands. From these the block forms five condition flags for the operation just completed. It stores them as the current field and compares them against a five-bit trap enable mask. It raises a one-cycle trap request when an enabled condition occurs. When no trap is taken, it folds the flags into the sticky accrued field.

Underflow detection depends on the mask. With underflow trapping disabled, a tiny result counts as underflow only if it is also inexact. With underflow trapping enabled, any tiny result counts. A result that is exactly zero before rounding never counts as underflow. A zero divided by zero is reported as invalid, not as divide-by-zero.

Software can load the current field, the accrued field and the mask in one write. That write wins over an operation finishing in the same cycle.

Top module: `fpx_flag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cur_flags`, `acc_flags`, `trap_mask` and `trap_req` are all zero.
- R2: All five-bit fields use the bit order [4] invalid, [3] overflow, [2] underflow, [1] divide-by-zero, [0] inexact. On a clock edge with `op_done` high and `sw_we` low, `cur_flags` is replaced by the flags of that operation. With neither `op_done` nor `sw_we` high, it holds its value.
- R3: The overflow flag equals `op_overflow` and the inexact flag equals `op_inexact`. The invalid flag is set by `op_invalid` or by a zero-by-zero divide.
- R4: The divide-by-zero flag is set when `op_divisor_zero` is high and `op_dividend_zero` is low. When both are high, the divide-by-zero flag stays clear and the invalid flag is set.
- R5: With `trap_mask[2]` clear, the underflow flag is set only when `op_tiny` and `op_inexact` are both high and `op_zero` is low. A tiny result that is exact gives no underflow.
- R6: With `trap_mask[2]` set, the underflow flag is set whenever `op_tiny` is high and `op_zero` is low, whatever the value of `op_inexact`.
- R7: When `op_zero` is high, the underflow flag is clear in both mask modes.
- R8: `trap_req` is high for exactly the one cycle after an operation's completion edge, and only if some new current flag has its mask bit set. Otherwise it is low.
- R9: On an operation that takes no trap, `acc_flags` becomes its old value ORed with the new flags. On an operation that takes a trap, `acc_flags` is left unchanged.
- R10: A clock edge with `sw_we` high loads `cur_flags`, `acc_flags` and `trap_mask` from `sw_cur`, `sw_acc` and `sw_mask`. An `op_done` in the same cycle is ignored, and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_done | input | 1 | Operation completion strobe |
| op_tiny | input | 1 | Unrounded result below smallest normalized magnitude |
| op_zero | input | 1 | Unrounded result exactly zero |
| op_inexact | input | 1 | Rounded result differs from exact result |
| op_overflow | input | 1 | Rounded magnitude above largest normalized number |
| op_invalid | input | 1 | Improper operand for the operation |
| op_dividend_zero | input | 1 | Divide with zero dividend |
| op_divisor_zero | input | 1 | Divide with zero divisor |
| sw_we | input | 1 | Software write strobe |
| sw_cur | input | 5 | Value written to the current field |
| sw_acc | input | 5 | Value written to the accrued field |
| sw_mask | input | 5 | Value written to the trap enable mask |
| cur_flags | output | 5 | Current exception field |
| acc_flags | output | 5 | Accrued exception field |
| trap_mask | output | 5 | Trap enable mask |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The main function is driven with a table of status patterns, each run under its own mask. The tiny/inexact/zero combinations under both underflow mask settings separate the two underflow rules, and the zero-result cases show that zero suppresses underflow. Divide patterns with only a zero divisor, with both operands zero, and with only a zero dividend show which of divide-by-zero and invalid is raised. Further patterns with masked and unmasked conditions decide whether the trap fires and whether the accrued field absorbs the new flags or is kept.

// File: rtl/fpx_pkg.sv
// Package: shared widths, flag bit positions and the per-operation status record.
// Assumes the field bit order invalid, overflow, underflow, divide-by-zero, inexact (MSB..LSB).
package fpx_pkg;
    localparam int FLAG_W = 5;
    localparam int B_INV  = 4;
    localparam int B_OVF  = 3;
    localparam int B_UNF  = 2;
    localparam int B_DZ   = 1;
    localparam int B_NX   = 0;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef struct packed {
        logic tiny;
        logic zero;
        logic inexact;
        logic ovf;
        logic inv;
        logic dvd_zero;
        logic dvs_zero;
    } op_status_t;
endpackage

// File: rtl/fpx_classify.sv
// Module: turns the raw status of one finished operation into five condition flags.
// Assumes the divide operand class inputs are only raised for divide operations and
// that a nonzero dividend is finite; purely combinational.
module fpx_classify
    import fpx_pkg::*;
(
    input  op_status_t st,
    input  logic       unf_trap_en,
    output flags_t     flags
);
    logic tiny_counts;
    logic zero_by_zero;

    // Underflow rule: the trap-enable mode counts any tiny result, the other needs inexactness too.
    always_comb begin
        if (st.zero)
            tiny_counts = 1'b0;
        else if (unf_trap_en)
            tiny_counts = st.tiny;
        else
            tiny_counts = st.tiny & st.inexact;
    end

    // Divide classes: zero by zero is invalid, nonzero by zero is divide-by-zero.
    always_comb begin
        zero_by_zero      = st.dvd_zero & st.dvs_zero;
        flags             = '0;
        flags[B_INV]      = st.inv | zero_by_zero;
        flags[B_OVF]      = st.ovf;
        flags[B_UNF]      = tiny_counts;
        flags[B_DZ]       = st.dvs_zero & ~st.dvd_zero;
        flags[B_NX]       = st.inexact;
    end
endmodule

// File: rtl/fpx_trap_gen.sv
// Module: decides whether an operation's new flags hit an enabled trap.
// Assumes fire marks a cycle in which an operation is actually committed; combinational.
module fpx_trap_gen
    import fpx_pkg::*;
(
    input  flags_t flags,
    input  flags_t mask,
    input  logic   fire,
    output logic   trap_hit
);
    flags_t hit_vec;

    // One enable gate per condition.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_gate
        assign hit_vec[i] = flags[i] & mask[i];
    end

    // Any enabled condition on a committed operation requests a trap.
    always_comb trap_hit = fire & (|hit_vec);
endmodule

// File: rtl/fpx_flag_regs.sv
// Module: holds the current field, accrued field, mask and the trap pulse register.
// Assumes sw_we has priority over op_done; accrual is suppressed on a trapping operation.
module fpx_flag_regs
    import fpx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sw_we,
    input  flags_t sw_cur,
    input  flags_t sw_acc,
    input  flags_t sw_mask,
    input  logic   op_commit,
    input  flags_t new_flags,
    input  logic   trap_hit,
    output flags_t cur_q,
    output flags_t acc_q,
    output flags_t mask_q,
    output logic   trap_q
);
    // Current field and mask: software load first, then operation overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            mask_q <= '0;
        end else if (sw_we) begin
            cur_q  <= sw_cur;
            mask_q <= sw_mask;
        end else if (op_commit) begin
            cur_q  <= new_flags;
        end
    end

    // Accrued field: one sticky cell per condition.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[i] <= 1'b0;
            else if (sw_we)
                acc_q[i] <= sw_acc[i];
            else if (op_commit && !trap_hit)
                acc_q[i] <= acc_q[i] | new_flags[i];
        end
    end

    // Trap pulse register: high for the cycle after a trapping operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_q <= 1'b0;
        else
            trap_q <= trap_hit;
    end

    AST_ACC_KEPT_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> acc_q == $past(acc_q)); // R9
    AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R9
    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !op_commit) |=> $stable(cur_q)); // R2
endmodule

// File: rtl/fpx_flag_ctrl.sv
// Module: top of the floating-point exception flag and trap controller.
// Assumes one status record per op_done strobe; trap_req follows one cycle later.
module fpx_flag_ctrl
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_done,
    input  logic             op_tiny,
    input  logic             op_zero,
    input  logic             op_inexact,
    input  logic             op_overflow,
    input  logic             op_invalid,
    input  logic             op_dividend_zero,
    input  logic             op_divisor_zero,
    input  logic             sw_we,
    input  logic [4:0]       sw_cur,
    input  logic [4:0]       sw_acc,
    input  logic [4:0]       sw_mask,
    output logic [4:0]       cur_flags,
    output logic [4:0]       acc_flags,
    output logic [4:0]       trap_mask,
    output logic             trap_req
);
    op_status_t st;
    flags_t     new_flags;
    logic       op_commit;
    logic       trap_hit;

    // Pack the status pins and qualify the completion with software priority.
    always_comb begin
        st        = '{tiny: op_tiny, zero: op_zero, inexact: op_inexact, ovf: op_overflow,
                      inv: op_invalid, dvd_zero: op_dividend_zero, dvs_zero: op_divisor_zero};
        op_commit = op_done & ~sw_we;
    end

    fpx_classify u_classify (
        .st          (st),
        .unf_trap_en (trap_mask[B_UNF]),
        .flags       (new_flags)
    );

    fpx_trap_gen u_trap (
        .flags    (new_flags),
        .mask     (trap_mask),
        .fire     (op_commit),
        .trap_hit (trap_hit)
    );

    fpx_flag_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (sw_we),
        .sw_cur    (sw_cur),
        .sw_acc    (sw_acc),
        .sw_mask   (sw_mask),
        .op_commit (op_commit),
        .new_flags (new_flags),
        .trap_hit  (trap_hit),
        .cur_q     (cur_flags),
        .acc_q     (acc_flags),
        .mask_q    (trap_mask),
        .trap_q    (trap_req)
    );

    AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (cur_flags == $past(sw_cur)) && (acc_flags == $past(sw_acc))
                  && (trap_mask == $past(sw_mask)) && !trap_req); // R10
    AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(op_done) && !$past(sw_we) && ((cur_flags & trap_mask) != '0))); // R8
    AST_ZERO_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we && op_zero) |=> !cur_flags[B_UNF]); // R7
    AST_ZERO_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we && op_dividend_zero && op_divisor_zero)
            |=> cur_flags[B_INV] && !cur_flags[B_DZ]); // R4
    AST_OVF_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we) |=> cur_flags[B_OVF] == $past(op_overflow)); // R3
endmodule

// File: tb/fpx_flag_ctrl_bench.sv
module fpx_flag_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_done = 0, op_tiny = 0, op_zero = 0, op_inexact = 0, op_overflow = 0;
    logic op_invalid = 0, op_dividend_zero = 0, op_divisor_zero = 0;
    logic sw_we = 0;
    logic [4:0] sw_cur = 0, sw_acc = 0, sw_mask = 0;
    logic [4:0] cur_flags, acc_flags, trap_mask;
    logic trap_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fpx_flag_ctrl u_fpx_flag_ctrl (.*);

    // Vector: mask[17:13] tiny zero inexact ovf inv dvdz dvsz [12:6] exp_cur[5:1] exp_trap[0]
    // Flag order: [4] INV [3] OVF [2] UNF [1] DZ [0] NX
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {5'b00000, 7'b1010000, 5'b00101, 1'b0}, // R5 tiny inexact
        {5'b00000, 7'b1000000, 5'b00000, 1'b0}, // R5 tiny exact
        {5'b00100, 7'b1000000, 5'b00100, 1'b1}, // R6 tiny exact, unf trap on
        {5'b00100, 7'b1100000, 5'b00000, 1'b0}, // R7 zero, unf trap on
        {5'b00000, 7'b1110000, 5'b00001, 1'b0}, // R7 zero, unf trap off
        {5'b00000, 7'b0011000, 5'b01001, 1'b0}, // R3 overflow inexact
        {5'b01000, 7'b0011000, 5'b01001, 1'b1}, // R8 overflow trapped
        {5'b00000, 7'b0000001, 5'b00010, 1'b0}, // R4 x/0
        {5'b00010, 7'b0000011, 5'b10000, 1'b0}, // R4 0/0 -> invalid, dz mask no trap
        {5'b10000, 7'b0000100, 5'b10000, 1'b1}, // R3 invalid trapped
        {5'b00001, 7'b1010000, 5'b00101, 1'b1}, // R8 inexact trapped
        {5'b11011, 7'b1010000, 5'b00101, 1'b1}, // R5 unf off, nx traps
        {5'b00000, 7'b0000010, 5'b00000, 1'b0}  // R4 zero dividend only
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic sw_load(input logic [4:0] c, input logic [4:0] a, input logic [4:0] m);
        @(negedge clk);
        sw_we = 1; sw_cur = c; sw_acc = a; sw_mask = m;
        @(negedge clk);
        sw_we = 0;
    endtask

    task automatic op_run(input logic [6:0] s);
        @(negedge clk);
        {op_tiny, op_zero, op_inexact, op_overflow, op_invalid, op_dividend_zero, op_divisor_zero} = s;
        op_done = 1;
        @(negedge clk);
        op_done = 0;
        {op_tiny, op_zero, op_inexact, op_overflow, op_invalid, op_dividend_zero, op_divisor_zero} = '0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cur", cur_flags, 5'b0);
        check("R1 acc", acc_flags, 5'b0);
        check("R1 mask", trap_mask, 5'b0);
        check("R1 trap", {4'b0, trap_req}, 5'b0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            sw_load(5'b0, 5'b0, v[17:13]);
            op_run(v[12:6]);
            check($sformatf("R2 vec%0d cur", i), cur_flags, v[5:1]);
            check($sformatf("R8 vec%0d trap", i), {4'b0, trap_req}, {4'b0, v[0]});
            check($sformatf("R9 vec%0d acc", i), acc_flags, v[0] ? 5'b0 : v[5:1]);
            @(negedge clk);
            check($sformatf("R8 vec%0d pulse end", i), {4'b0, trap_req}, 5'b0);
            check($sformatf("R2 vec%0d hold", i), cur_flags, v[5:1]);
        end

        // R9 accrual across two untrapped ops
        sw_load(5'b0, 5'b0, 5'b0);
        op_run(7'b0010000);
        op_run(7'b0001000);
        check("R9 acc or", acc_flags, 5'b01001);
        check("R2 overwrite", cur_flags, 5'b01000);
        op_run(7'b0000000);
        check("R2 overwrite clean", cur_flags, 5'b00000);
        check("R9 acc kept", acc_flags, 5'b01001);

        // R9 trapped op leaves accrued untouched
        sw_load(5'b00000, 5'b00001, 5'b01000);
        op_run(7'b0001000);
        check("R9 acc on trap", acc_flags, 5'b00001);
        check("R8 trap", {4'b0, trap_req}, 5'b00001);

        // R10 software write beats a concurrent op
        @(negedge clk);
        sw_we = 1; sw_cur = 5'b10010; sw_acc = 5'b00110; sw_mask = 5'b11111;
        op_done = 1; op_overflow = 1; op_inexact = 1;
        @(negedge clk);
        sw_we = 0; op_done = 0; op_overflow = 0; op_inexact = 0;
        check("R10 cur", cur_flags, 5'b10010);
        check("R10 acc", acc_flags, 5'b00110);
        check("R10 mask", trap_mask, 5'b11111);
        check("R10 no trap", {4'b0, trap_req}, 5'b0);

        // R6 exact tiny with all traps on
        op_run(7'b1000000);
        check("R6 cur", cur_flags, 5'b00100);
        check("R6 trap", {4'b0, trap_req}, 5'b00001);

        // R1 reset again clears everything
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check("R1 re-reset cur", cur_flags, 5'b0);
        check("R1 re-reset mask", trap_mask, 5'b0);
        finish_up();
    end
endmodule